// File: doc/BRIEF.md
# Logical and Conditional Move Unit

This block is the 64-bit logical slice of an integer execute stage. Each issued operation carries a 7-bit function code, operand A, a second operand that is either a register value or an 8-bit literal, the index of the A register, the present value of the destination register and a system-mode bit. The block returns a result, a write-enable for the destination and a flag that marks the operation as illegal.

It covers three kinds of work. Bitwise operations may use B directly or B inverted. Conditional moves test operand A and copy B into the destination when the test holds. Two feature-query functions report a capability mask and an implementation level, and each accepts only specific operand forms.

Every issued operation produces exactly one registered response one clock later. The register file and fault delivery sit outside the block.

Top module: `lcm_unit`

## Requirements
- R1: Bitwise codes give these results from A and the second operand B: 0x00 A&B, 0x08 A&~B, 0x20 A|B, 0x28 A|~B, 0x40 A^B, 0x48 ~(A^B). Each is written with `wr_en`=1 and `illegal`=0.
- R2: When `lit_sel`=1, B is the 8-bit `lit` zero-extended to 64 bits. When `lit_sel`=0, B is `op_b`.
- R3: Code 0x14 moves when bit 0 of A is 1. Code 0x16 moves when bit 0 of A is 0.
- R4: The signed tests on A are 0x24 (A==0), 0x26 (A!=0), 0x44 (A<0), 0x46 (A>=0), 0x64 (A<=0) and 0x66 (A>0).
- R5: A conditional move whose test fails gives `wr_en`=0, `illegal`=0 and `result` equal to `rc_old`.
- R6: A conditional move whose test holds gives `wr_en`=1 and `result` equal to B.
- R7: Code 0x61 with `ra_idx`=31 returns B with bits 0, 1, 2 and 4 cleared, and is written.
- R8: Code 0x6c with `ra_idx`=31, `lit_sel`=1 and `lit`=1 returns 1 when `sys_mode`=1 and 2 when `sys_mode`=0, and is written.
- R9: Code 0x61 or 0x6c without its operand conditions gives `illegal`=1, `wr_en`=0 and `result`=0.
- R10: Any other function code gives `illegal`=1, `wr_en`=0 and `result`=0.
- R11: `done` is 1 exactly in the cycle after an `issue` cycle, and the response is valid in that cycle. When `done`=0, both `wr_en` and `illegal` are 0. Reset clears `done`, `wr_en`, `illegal` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| func | input | 7 | Function code |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Register operand B |
| lit | input | 8 | Literal operand |
| lit_sel | input | 1 | Selects the literal as operand B |
| ra_idx | input | 5 | Register index of operand A |
| rc_old | input | 64 | Current destination value |
| sys_mode | input | 1 | System mode, used by the implementation query |
| done | output | 1 | Response valid |
| result | output | 64 | Result value |
| wr_en | output | 1 | Destination write-enable |
| illegal | output | 1 | Illegal-function flag |

## Verification
The assertions assume that all inputs are stable and known whenever `issue` is high. They also assume that `rc_old` is the destination value for the same operation, so a failed move can be compared against it one cycle later. The bench drives every input on the falling edge and holds it for a full cycle. It picks function codes from the legal set and from random 7-bit values. It biases `ra_idx` toward 31 and `lit` toward 1, so that both the legal and the illegal query forms occur often. It biases A toward zero, toward negative values and toward small positive values, so that each side of every conditional-move test is reached.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  localparam int FUNC_W = 7;

  localparam logic [FUNC_W-1:0] F_AND   = 7'h00;
  localparam logic [FUNC_W-1:0] F_ANDN  = 7'h08;
  localparam logic [FUNC_W-1:0] F_OR    = 7'h20;
  localparam logic [FUNC_W-1:0] F_ORN   = 7'h28;
  localparam logic [FUNC_W-1:0] F_XOR   = 7'h40;
  localparam logic [FUNC_W-1:0] F_XNOR  = 7'h48;
  localparam logic [FUNC_W-1:0] F_MV_LS = 7'h14;
  localparam logic [FUNC_W-1:0] F_MV_LC = 7'h16;
  localparam logic [FUNC_W-1:0] F_MV_EQ = 7'h24;
  localparam logic [FUNC_W-1:0] F_MV_NE = 7'h26;
  localparam logic [FUNC_W-1:0] F_MV_LT = 7'h44;
  localparam logic [FUNC_W-1:0] F_MV_GE = 7'h46;
  localparam logic [FUNC_W-1:0] F_MV_LE = 7'h64;
  localparam logic [FUNC_W-1:0] F_MV_GT = 7'h66;
  localparam logic [FUNC_W-1:0] F_QMASK = 7'h61;
  localparam logic [FUNC_W-1:0] F_QIMPL = 7'h6c;

  // Bits cleared by the capability-mask query.
  localparam logic [7:0] QMASK_CLR = 8'h17;

  // Evaluates a move test on A. The caller ignores the result for codes
  // that are not moves.
  function automatic logic move_test(input logic [FUNC_W-1:0] f,
                                     input logic lsb, input logic neg,
                                     input logic zero);
    case (f)
      F_MV_LS: move_test = lsb;
      F_MV_LC: move_test = !lsb;
      F_MV_EQ: move_test = zero;
      F_MV_NE: move_test = !zero;
      F_MV_LT: move_test = neg;
      F_MV_GE: move_test = !neg;
      F_MV_LE: move_test = neg || zero;
      F_MV_GT: move_test = !neg && !zero;
      default: move_test = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lcm_bitwise.sv
module lcm_bitwise import lcm_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   res,
  output logic              hit
);
  logic [XLEN-1:0] b_use;

  // Bit 3 of the code selects the inverted form of B in every bitwise code.
  assign b_use = func[3] ? ~b : b;

  always_comb begin
    hit = 1'b1;
    unique case (func)
      F_AND, F_ANDN: res = a & b_use;
      F_OR,  F_ORN:  res = a | b_use;
      F_XOR, F_XNOR: res = a ^ b_use;
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lcm_cmov_test.sv
module lcm_cmov_test import lcm_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   a,
  output logic              is_move,
  output logic              take
);
  logic a_neg, a_zero;

  assign a_neg  = a[XLEN-1];
  assign a_zero = (a == '0);

  always_comb begin
    case (func)
      F_MV_LS, F_MV_LC, F_MV_EQ, F_MV_NE,
      F_MV_LT, F_MV_GE, F_MV_LE, F_MV_GT: is_move = 1'b1;
      default: is_move = 1'b0;
    endcase
  end

  assign take = is_move && move_test(func, a[0], a_neg, a_zero);
endmodule

// File: rtl/lcm_query.sv
module lcm_query import lcm_pkg::*; #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int LIT_W = 8
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic              lit_sel,
  input  logic [LIT_W-1:0]  lit,
  input  logic [XLEN-1:0]   b,
  input  logic              sys_mode,
  output logic              is_query,
  output logic              ok,
  output logic [XLEN-1:0]   res
);
  localparam logic [IDX_W-1:0] ZERO_REG = IDX_W'((1 << IDX_W) - 1);
  localparam logic [XLEN-1:0]  CLR_MASK = XLEN'(QMASK_CLR);

  logic ra_ok;

  assign ra_ok = (ra_idx == ZERO_REG);

  always_comb begin
    is_query = 1'b0;
    ok       = 1'b0;
    res      = '0;
    if (func == F_QMASK) begin
      is_query = 1'b1;
      ok       = ra_ok;
      res      = b & ~CLR_MASK;
    end else if (func == F_QIMPL) begin
      is_query = 1'b1;
      ok       = ra_ok && lit_sel && (lit == LIT_W'(1));
      res      = sys_mode ? XLEN'(1) : XLEN'(2);
    end
  end
endmodule

// File: rtl/lcm_unit.sv
module lcm_unit import lcm_pkg::*; #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int LIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [LIT_W-1:0]  lit,
  input  logic              lit_sel,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [XLEN-1:0]   rc_old,
  input  logic              sys_mode,
  output logic              done,
  output logic [XLEN-1:0]   result,
  output logic              wr_en,
  output logic              illegal
);
  localparam logic [IDX_W-1:0] ZERO_REG = IDX_W'((1 << IDX_W) - 1);

  logic [XLEN-1:0] b_eff, bw_res, q_res, res_nx;
  logic            bw_hit, mv_is, mv_take, q_is, q_ok;
  logic            we_nx, ill_nx;

  assign b_eff = lit_sel ? {{(XLEN-LIT_W){1'b0}}, lit} : op_b;

  lcm_bitwise #(.XLEN(XLEN)) u_bw (
    .func(func), .a(op_a), .b(b_eff), .res(bw_res), .hit(bw_hit)
  );

  lcm_cmov_test #(.XLEN(XLEN)) u_mv (
    .func(func), .a(op_a), .is_move(mv_is), .take(mv_take)
  );

  lcm_query #(.XLEN(XLEN), .IDX_W(IDX_W), .LIT_W(LIT_W)) u_q (
    .func(func), .ra_idx(ra_idx), .lit_sel(lit_sel), .lit(lit), .b(b_eff),
    .sys_mode(sys_mode), .is_query(q_is), .ok(q_ok), .res(q_res)
  );

  always_comb begin
    res_nx = '0;
    we_nx  = 1'b0;
    ill_nx = 1'b0;
    if (bw_hit) begin
      res_nx = bw_res;
      we_nx  = 1'b1;
    end else if (mv_is) begin
      res_nx = mv_take ? b_eff : rc_old;
      we_nx  = mv_take;
    end else if (q_is && q_ok) begin
      res_nx = q_res;
      we_nx  = 1'b1;
    end else begin
      ill_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      result  <= '0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= issue;
      result  <= issue ? res_nx : '0;
      wr_en   <= issue && we_nx;
      illegal <= issue && ill_nx;
    end
  end

  // R11
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> done);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!wr_en && !illegal));
  // R9
  no_write_when_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en);
  // R5
  cmov_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && mv_is && !mv_take) |=> (!wr_en && !illegal && result == $past(rc_old)));
  // R6
  cmov_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && mv_take) |=> (wr_en && result == $past(b_eff)));
  // R9
  qmask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && func == F_QMASK && ra_idx != ZERO_REG) |=> illegal);
  // R8
  qimpl_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && q_is && q_ok && func == F_QIMPL) |=>
      (result == XLEN'(1) || result == XLEN'(2)));
endmodule

// File: tb/lcm_unit_test.sv
`timescale 1ns/1ps
module lcm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [6:0]  func = '0;
  logic [63:0] op_a = '0, op_b = '0, rc_old = '0;
  logic [7:0]  lit = '0;
  logic        lit_sel = 1'b0;
  logic [4:0]  ra_idx = '0;
  logic        sys_mode = 1'b0;
  logic        done, wr_en, illegal;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lcm_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .func(func), .op_a(op_a),
    .op_b(op_b), .lit(lit), .lit_sel(lit_sel), .ra_idx(ra_idx),
    .rc_old(rc_old), .sys_mode(sys_mode), .done(done), .result(result),
    .wr_en(wr_en), .illegal(illegal)
  );

  // Reference: returns {illegal, we, result}
  function automatic logic [65:0] ref_model(
      input logic [6:0] f, input logic [63:0] a, input logic [63:0] rb,
      input logic [7:0] l, input logic ls, input logic [4:0] ri,
      input logic [63:0] old, input logic sm);
    logic [63:0] b;
    logic signed [63:0] sa;
    logic cond;
    b  = ls ? {56'd0, l} : rb;
    sa = a;
    case (f)
      7'h00: return {2'b01, a & b};
      7'h08: return {2'b01, a & ~b};
      7'h20: return {2'b01, a | b};
      7'h28: return {2'b01, a | ~b};
      7'h40: return {2'b01, a ^ b};
      7'h48: return {2'b01, ~(a ^ b)};
      7'h14, 7'h16, 7'h24, 7'h26, 7'h44, 7'h46, 7'h64, 7'h66: begin
        case (f)
          7'h14: cond = (a % 2) == 1;
          7'h16: cond = (a % 2) == 0;
          7'h24: cond = sa == 0;
          7'h26: cond = sa != 0;
          7'h44: cond = sa < 0;
          7'h46: cond = sa >= 0;
          7'h64: cond = sa <= 0;
          default: cond = sa > 0;
        endcase
        return cond ? {2'b01, b} : {2'b00, old};
      end
      7'h61: return (ri == 31) ? {2'b01, b - (b & 64'h17)} : {2'b10, 64'd0};
      7'h6c: return (ri == 31 && ls && l == 1) ?
                    {2'b01, (sm ? 64'd1 : 64'd2)} : {2'b10, 64'd0};
      default: return {2'b10, 64'd0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [6:0] f,
      input logic [63:0] a, input logic [63:0] rb, input logic [7:0] l,
      input logic ls, input logic [4:0] ri, input logic [63:0] old,
      input logic sm);
    logic [65:0] e;
    @(negedge clk);
    issue = 1'b1; func = f; op_a = a; op_b = rb; lit = l; lit_sel = ls;
    ra_idx = ri; rc_old = old; sys_mode = sm;
    e = ref_model(f, a, rb, l, ls, ri, old, sm);
    @(negedge clk);
    issue = 1'b0;
    check({tag, " done"}, {63'd0, done}, 64'd1);
    check({tag, " result"}, result, e[63:0]);
    check({tag, " wr_en"}, {63'd0, wr_en}, {63'd0, e[64]});
    check({tag, " illegal"}, {63'd0, illegal}, {63'd0, e[65]});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] codes [16] = '{7'h00, 7'h08, 7'h20, 7'h28, 7'h40, 7'h48,
      7'h14, 7'h16, 7'h24, 7'h26, 7'h44, 7'h46, 7'h64, 7'h66, 7'h61, 7'h6c};
    logic [31:0] seed;
    seed = $urandom(32'h1c0ffee);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset done", {63'd0, done}, 64'd0);
    check("R11 reset result", result, 64'd0);
    check("R11 reset wr_en", {63'd0, wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle illegal", {63'd0, illegal}, 64'd0);

    run_op("R1 and",  7'h00, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FF00_FF00_FF00, 8'h0, 0, 5'd3, 64'd0, 0);
    run_op("R1 andn", 7'h08, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FF00_FF00_FF00, 8'h0, 0, 5'd3, 64'd0, 0);
    run_op("R1 ornot",7'h28, 64'h0, 64'h1, 8'h0, 0, 5'd3, 64'd0, 0);
    run_op("R1 xnor", 7'h48, 64'hAAAA, 64'hAAAA, 8'h0, 0, 5'd3, 64'd0, 0);
    run_op("R2 lit",  7'h20, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, 1, 5'd3, 64'd0, 0);
    run_op("R3 lbs",  7'h14, 64'h3, 64'h55, 8'h0, 0, 5'd1, 64'h77, 0);
    run_op("R3 lbc",  7'h16, 64'h3, 64'h55, 8'h0, 0, 5'd1, 64'h77, 0);
    run_op("R4 eq",   7'h24, 64'h0, 64'h9, 8'h0, 0, 5'd1, 64'h77, 0);
    run_op("R4 lt",   7'h44, 64'h8000_0000_0000_0000, 64'h9, 8'h0, 0, 5'd1, 64'h77, 0);
    run_op("R4 le",   7'h64, 64'h0, 64'h9, 8'h0, 0, 5'd1, 64'h77, 0);
    run_op("R5 gt fail", 7'h66, 64'h0, 64'h9, 8'h0, 0, 5'd1, 64'hDEAD, 0);
    run_op("R6 ge take", 7'h46, 64'h7FFF_FFFF_FFFF_FFFF, 64'h9, 8'h0, 0, 5'd1, 64'hDEAD, 0);
    run_op("R7 qmask", 7'h61, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, 0, 5'd31, 64'd0, 0);
    run_op("R8 qimpl sys", 7'h6c, 64'h0, 64'h0, 8'h1, 1, 5'd31, 64'd0, 1);
    run_op("R8 qimpl usr", 7'h6c, 64'h0, 64'h0, 8'h1, 1, 5'd31, 64'd0, 0);
    run_op("R9 qmask ra", 7'h61, 64'h0, 64'hFF, 8'h0, 0, 5'd30, 64'd0, 0);
    run_op("R9 qimpl reg", 7'h6c, 64'h0, 64'h1, 8'h1, 0, 5'd31, 64'd0, 0);
    run_op("R9 qimpl lit2", 7'h6c, 64'h0, 64'h0, 8'h2, 1, 5'd31, 64'd0, 0);
    run_op("R10 unknown", 7'h25, 64'h1, 64'h1, 8'h0, 0, 5'd31, 64'd5, 0);
    // R11 response drops when issue is low
    @(negedge clk);
    check("R11 done low", {63'd0, done}, 64'd0);
    check("R11 wr_en low", {63'd0, wr_en}, 64'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [6:0] f;
      logic [63:0] a;
      logic [7:0] l;
      logic [4:0] ri;
      f  = ($urandom % 4 == 0) ? 7'($urandom) : codes[$urandom % 16];
      case ($urandom % 4)
        0: a = 64'd0;
        1: a = {1'b1, 63'($urandom)};
        2: a = 64'($urandom % 4);
        default: a = {$urandom, $urandom};
      endcase
      l  = ($urandom % 2) ? 8'd1 : 8'($urandom);
      ri = ($urandom % 2) ? 5'd31 : 5'($urandom);
      run_op("R1-mix rand", f, a, {$urandom, $urandom}, l, 1'($urandom),
             ri, {$urandom, $urandom}, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule